// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps wall-clock time for a chip that has a slow reference clock. It divides that clock down to one-second steps and counts seconds, minutes and hours of the day, plus a free-running binary day number. A small register port lets software load and read every time field, program an alarm instant, and set a control word that holds the enable bit and picks one of three reference rates.

Each completed second appears on `sec_tick` as a one-cycle pulse. When a counted second lands exactly on the programmed day, hour, minute and second, `alarm_pulse` fires for one cycle. Interrupt status and masking sit in a separate block downstream. The time fields live in separate registers, so a carry can happen between two reads. Software deals with this by reading twice and comparing.

The register port is synchronous to the reference clock. Reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `rtc_core`

## Requirements
- R1: After reset every time, alarm and control register reads as zero, and `sec_tick` and `alarm_pulse` are low.
- R2: The control register holds the enable in bit 7 and the rate select in bits 6:5. Reading it back returns exactly those written bits and zero elsewhere, so the enable reads 1 once it is set.
- R3: While enabled, `sec_tick` pulses once every DIV0 clocks for select 0, every DIV1 clocks for select 1, and every DIV2 clocks for select 2. Select 3 behaves as select 0.
- R4: With the enable clear, no tick is issued and every time field keeps its value.
- R5: Each tick advances the time. Seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and increment the day count.
- R6: The hour/minute register (offset 0x00) and the alarm hour/minute register (offset 0x08) hold the hour in bits 15:8 and the minute in bits 7:0. Seconds are at 0x04, alarm seconds at 0x0C, control at 0x10, day at 0x20 and alarm day at 0x24.
- R7: A write to the seconds register restarts the divider. The next tick comes exactly one full divisor period after the write edge.
- R8: A write to any time register loads that field at the next edge. If a tick falls in the same cycle, the advance for that second is dropped.
- R9: `alarm_pulse` is high for exactly one cycle, in the cycle after the tick that brings day, hour, minute and second equal to the alarm registers. Making the time equal to the alarm by a register write raises no pulse.
- R10: The day count is a plain binary counter of DAY_W bits. It wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (6) | Byte address of the register |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| sec_tick | output | 1 | One-cycle pulse per elapsed second |
| alarm_pulse | output | 1 | One-cycle pulse on an alarm match |

## Verification
The counter is started from chosen preset times, each placed just before a different carry boundary: a plain second, a minute carry, a full end of day, and the all-ones day wrap. This separates a faulty limit at each stage from a faulty carry chain. The divider is measured under all four select codes and right after a seconds write, which tells a wrong divisor apart from a missing restart. Alarm runs contrast a match reached by counting with a match created by a write, and a register write placed exactly on a tick shows whether writes take priority over the advance.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BUS_W  = 16;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_HM      = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_SEC     = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_ALM_HM  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_ALM_SEC = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_DAY     = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_ALM_DAY = 6'h24;

    localparam logic [5:0] SEC_LAST  = 6'd59;
    localparam logic [5:0] MIN_LAST  = 6'd59;
    localparam logic [4:0] HOUR_LAST = 5'd23;

    typedef enum logic [1:0] {
        RATE_A   = 2'd0,
        RATE_B   = 2'd1,
        RATE_C   = 2'd2,
        RATE_RSV = 2'd3
    } rate_sel_e;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } hms_t;

    typedef struct packed {
        logic      day_carry;
        hms_t      t;
    } hms_step_t;

    typedef struct packed {
        logic      en;
        rate_sel_e sel;
    } ctrl_t;

    function automatic hms_step_t hms_advance(hms_t cur);
        hms_step_t r;
        r.day_carry = 1'b0;
        r.t         = cur;
        if (cur.sc >= SEC_LAST) begin
            r.t.sc = '0;
            if (cur.mn >= MIN_LAST) begin
                r.t.mn = '0;
                if (cur.hr >= HOUR_LAST) begin
                    r.t.hr      = '0;
                    r.day_carry = 1'b1;
                end else begin
                    r.t.hr = cur.hr + 5'd1;
                end
            end else begin
                r.t.mn = cur.mn + 6'd1;
            end
        end else begin
            r.t.sc = cur.sc + 6'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int DIV0 = 32768,
    parameter int DIV1 = 32000,
    parameter int DIV2 = 38400
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  rate_sel_e sel,
    input  logic      clr,
    output logic      tick
);
    localparam int DMAX  = (DIV0 > DIV1) ? ((DIV0 > DIV2) ? DIV0 : DIV2)
                                         : ((DIV1 > DIV2) ? DIV1 : DIV2);
    localparam int CNT_W = $clog2(DMAX);
    localparam logic [CNT_W-1:0] LIM0 = CNT_W'(DIV0 - 1);
    localparam logic [CNT_W-1:0] LIM1 = CNT_W'(DIV1 - 1);
    localparam logic [CNT_W-1:0] LIM2 = CNT_W'(DIV2 - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             at_lim;

    always_comb begin
        unique case (sel)
            RATE_B:  lim = LIM1;
            RATE_C:  lim = LIM2;
            default: lim = LIM0;
        endcase
    end

    assign at_lim = (cnt_q >= lim);
    assign tick   = en && !clr && at_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            if (at_lim) cnt_q <= '0;
            else        cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt_q));

    assert_restart_after_tick_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

    assert_clear_restarts_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0) && !tick);

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             ld_hm,
    input  logic             ld_sec,
    input  logic             ld_day,
    input  logic [4:0]       ld_hr_val,
    input  logic [5:0]       ld_mn_val,
    input  logic [5:0]       ld_sc_val,
    input  logic [DAY_W-1:0] ld_day_val,
    output hms_t             cur,
    output logic [DAY_W-1:0] day,
    output hms_t             nxt,
    output logic [DAY_W-1:0] nxt_day,
    output logic             any_ld
);
    hms_step_t step;

    assign any_ld  = ld_hm | ld_sec | ld_day;
    assign step    = hms_advance(cur);
    assign nxt     = step.t;
    assign nxt_day = step.day_carry ? day + DAY_W'(1) : day;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            day <= '0;
        end else if (any_ld) begin
            if (ld_hm) begin
                cur.hr <= ld_hr_val;
                cur.mn <= ld_mn_val;
            end
            if (ld_sec) cur.sc <= ld_sc_val;
            if (ld_day) day    <= ld_day_val;
        end else if (tick) begin
            cur <= nxt;
            day <= nxt_day;
        end
    end

    assert_sec_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !any_ld) |=> (cur.sc <= SEC_LAST));

    assert_day_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !any_ld && cur.sc == SEC_LAST && cur.mn == MIN_LAST && cur.hr == HOUR_LAST)
        |=> (day == $past(day) + DAY_W'(1)) && (cur.hr == '0));

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !any_ld) |=> ($stable(cur) && $stable(day)));

    assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && ld_hm) |=> (cur.sc == $past(cur.sc)));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_pkg::*;
#(
    parameter int DAY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             suppress,
    input  hms_t             nxt,
    input  logic [DAY_W-1:0] nxt_day,
    input  hms_t             alm,
    input  logic [DAY_W-1:0] alm_day,
    output logic             pulse
);
    logic hit;

    assign hit = (nxt == alm) && (nxt_day == alm_day);

    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= tick && !suppress && hit;
    end

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    assert_no_pulse_without_tick_R9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !pulse);

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV0  = 32768,
    parameter int DIV1  = 32000,
    parameter int DIV2  = 38400,
    parameter int DAY_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              sec_tick,
    output logic              alarm_pulse
);
    ctrl_t            ctrl_q;
    hms_t             alm_q;
    logic [DAY_W-1:0] alm_day_q;

    hms_t             cur_t, nxt_t;
    logic [DAY_W-1:0] cur_day, nxt_day;
    logic             any_ld;

    logic wr_hm, wr_sec, wr_day, wr_ctrl, wr_ahm, wr_asec, wr_aday;

    assign wr_hm   = bus_wr && (bus_addr == OFS_HM);
    assign wr_sec  = bus_wr && (bus_addr == OFS_SEC);
    assign wr_day  = bus_wr && (bus_addr == OFS_DAY);
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_ahm  = bus_wr && (bus_addr == OFS_ALM_HM);
    assign wr_asec = bus_wr && (bus_addr == OFS_ALM_SEC);
    assign wr_aday = bus_wr && (bus_addr == OFS_ALM_DAY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            alm_q     <= '0;
            alm_day_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.en  <= bus_wdata[7];
                ctrl_q.sel <= rate_sel_e'(bus_wdata[6:5]);
            end
            if (wr_ahm) begin
                alm_q.hr <= bus_wdata[12:8];
                alm_q.mn <= bus_wdata[5:0];
            end
            if (wr_asec) alm_q.sc  <= bus_wdata[5:0];
            if (wr_aday) alm_day_q <= bus_wdata[DAY_W-1:0];
        end
    end

    rtc_prescaler #(
        .DIV0 (DIV0),
        .DIV1 (DIV1),
        .DIV2 (DIV2)
    ) u_presc (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl_q.en),
        .sel  (ctrl_q.sel),
        .clr  (wr_sec),
        .tick (sec_tick)
    );

    rtc_time_counter #(
        .DAY_W (DAY_W)
    ) u_tod (
        .clk        (clk),
        .rst        (rst),
        .tick       (sec_tick),
        .ld_hm      (wr_hm),
        .ld_sec     (wr_sec),
        .ld_day     (wr_day),
        .ld_hr_val  (bus_wdata[12:8]),
        .ld_mn_val  (bus_wdata[5:0]),
        .ld_sc_val  (bus_wdata[5:0]),
        .ld_day_val (bus_wdata[DAY_W-1:0]),
        .cur        (cur_t),
        .day        (cur_day),
        .nxt        (nxt_t),
        .nxt_day    (nxt_day),
        .any_ld     (any_ld)
    );

    rtc_alarm_match #(
        .DAY_W (DAY_W)
    ) u_alm (
        .clk      (clk),
        .rst      (rst),
        .tick     (sec_tick),
        .suppress (any_ld),
        .nxt      (nxt_t),
        .nxt_day  (nxt_day),
        .alm      (alm_q),
        .alm_day  (alm_day_q),
        .pulse    (alarm_pulse)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_HM:      bus_rdata = {3'b0, cur_t.hr, 2'b0, cur_t.mn};
            OFS_SEC:     bus_rdata = BUS_W'(cur_t.sc);
            OFS_ALM_HM:  bus_rdata = {3'b0, alm_q.hr, 2'b0, alm_q.mn};
            OFS_ALM_SEC: bus_rdata = BUS_W'(alm_q.sc);
            OFS_CTRL:    bus_rdata = BUS_W'({ctrl_q.en, ctrl_q.sel, 5'b0});
            OFS_DAY:     bus_rdata = BUS_W'(cur_day);
            OFS_ALM_DAY: bus_rdata = BUS_W'(alm_day_q);
            default:     bus_rdata = '0;
        endcase
    end

    logic unused_wbits;
    assign unused_wbits = ^{bus_wdata[15:13], bus_wdata[4:0]};

    assert_sec_write_loads_R7: assert property (@(posedge clk) disable iff (rst)
        wr_sec |=> (cur_t.sc == $past(bus_wdata[5:0])));

    assert_ctrl_write_loads_R2: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_q.en == $past(bus_wdata[7])));

endmodule

// File: tb/tb_rtc_core.sv
`timescale 1ns/1ps
module tb_rtc_core;
    localparam int D0 = 8;
    localparam int D1 = 5;
    localparam int D2 = 11;
    localparam realtime CYC = 8.0;

    localparam logic [5:0] A_HM = 6'h00, A_SEC = 6'h04, A_AHM = 6'h08, A_ASEC = 6'h0C,
                           A_CTRL = 6'h10, A_DAY = 6'h20, A_ADAY = 6'h24;
    localparam logic [15:0] EN = 16'h0080;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sec_tick, alarm_pulse;

    int checks = 0;
    int fails = 0;
    int tick_cnt = 0;
    int alm_cnt = 0;
    int alm_at = -1;
    bit done = 0;

    typedef struct {
        logic [5:0]  addr;
        logic [15:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #(CYC/2) clk = ~clk;

    rtc_core #(.DIV0(D0), .DIV1(D1), .DIV2(D2), .DAY_W(16)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_tick(sec_tick), .alarm_pulse(alarm_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: event counters and scoreboard comparison
    always @(negedge clk) begin
        if (!rst) begin
            if (sec_tick) tick_cnt++;
            if (alarm_pulse) begin
                alm_cnt++;
                alm_at = tick_cnt;
            end
        end
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk(it.tag, {16'h0, bus_rdata}, {16'h0, it.exp});
        end
    end

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [5:0] a, input logic [15:0] e, input string tag);
        sb_item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); #1;
    endtask

    task automatic wait_ticks(input int n);
        int target;
        target = tick_cnt + n;
        while (tick_cnt < target) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wait_one_tick();
        do begin @(negedge clk); #1; end while (!sec_tick);
    endtask

    task automatic tick_gap(output int n);
        wait_one_tick();
        n = 0;
        do begin @(negedge clk); #1; n++; end while (!sec_tick);
    endtask

    task automatic set_time(input logic [15:0] d, input logic [15:0] hm, input logic [15:0] s);
        wr(A_DAY, d);
        wr(A_HM, hm);
        wr(A_SEC, s);
    endtask

    initial begin
        #(CYC * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        int gap, base, a0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk); #1;
        chk("R1 sec_tick", {31'h0, sec_tick}, 32'h0);
        chk("R1 alarm_pulse", {31'h0, alarm_pulse}, 32'h0);
        expect_rd(A_HM, 16'h0, "R1 hm");
        expect_rd(A_SEC, 16'h0, "R1 sec");
        expect_rd(A_AHM, 16'h0, "R1 alarm hm");
        expect_rd(A_ASEC, 16'h0, "R1 alarm sec");
        expect_rd(A_CTRL, 16'h0, "R1 ctrl");
        expect_rd(A_DAY, 16'h0, "R1 day");
        expect_rd(A_ADAY, 16'h0, "R1 alarm day");

        // R2: control readback
        wr(A_CTRL, 16'hFFFF);
        expect_rd(A_CTRL, 16'h00E0, "R2 ctrl all ones");
        wr(A_CTRL, 16'h0000);
        wr(A_CTRL, EN | 16'h0040);
        expect_rd(A_CTRL, 16'h00C0, "R2 enable reads one");
        wr(A_CTRL, 16'h0000);

        // R6: field packing
        wr(A_HM, 16'h0A1E);
        expect_rd(A_HM, 16'h0A1E, "R6 hm 10:30");
        wr(A_AHM, 16'h173B);
        expect_rd(A_AHM, 16'h173B, "R6 alarm hm 23:59");
        wr(A_ASEC, 16'd42);
        expect_rd(A_ASEC, 16'd42, "R6 alarm sec");
        wr(A_ADAY, 16'h1234);
        expect_rd(A_ADAY, 16'h1234, "R6 alarm day");

        // R4: disabled holds
        set_time(16'd3, 16'h0102, 16'd7);
        base = tick_cnt;
        repeat (40) @(posedge clk);
        @(negedge clk); #1;
        chk("R4 no ticks while off", tick_cnt - base, 0);
        expect_rd(A_SEC, 16'd7, "R4 sec held");
        expect_rd(A_HM, 16'h0102, "R4 hm held");

        // R3: divisor per select
        wr(A_CTRL, EN | 16'h0000);
        tick_gap(gap); chk("R3 select 0 period", gap, D0);
        wr(A_CTRL, EN | 16'h0020);
        tick_gap(gap); tick_gap(gap); chk("R3 select 1 period", gap, D1);
        wr(A_CTRL, EN | 16'h0040);
        tick_gap(gap); tick_gap(gap); chk("R3 select 2 period", gap, D2);
        wr(A_CTRL, EN | 16'h0060);
        tick_gap(gap); tick_gap(gap); chk("R3 select 3 acts as 0", gap, D0);

        // R7: seconds write restarts divider
        wr(A_CTRL, EN | 16'h0040);
        wait_one_tick();
        repeat (3) @(posedge clk);
        wr(A_SEC, 16'd20);
        gap = 0;
        do begin @(negedge clk); #1; gap++; end while (!sec_tick);
        chk("R7 first tick after sec write", gap, D2);

        // R5: second, minute, day carries
        wr(A_CTRL, 16'h0000);
        set_time(16'd0, 16'h0000, 16'd58);
        wr(A_CTRL, EN);
        wait_ticks(1);
        wr(A_CTRL, 16'h0000);
        expect_rd(A_SEC, 16'd59, "R5 plain second");
        set_time(16'd0, 16'h000A, 16'd59);
        wr(A_CTRL, EN);
        wait_ticks(1);
        wr(A_CTRL, 16'h0000);
        expect_rd(A_HM, 16'h000B, "R5 minute carry hm");
        expect_rd(A_SEC, 16'd0, "R5 minute carry sec");
        set_time(16'd5, 16'h173B, 16'd58);
        wr(A_CTRL, EN);
        wait_ticks(2);
        wr(A_CTRL, 16'h0000);
        expect_rd(A_DAY, 16'd6, "R5 day increments");
        expect_rd(A_HM, 16'h0000, "R5 hour wrap");
        expect_rd(A_SEC, 16'd0, "R5 sec wrap at day end");

        // R10: day wrap
        set_time(16'hFFFF, 16'h173B, 16'd59);
        wr(A_CTRL, EN);
        wait_ticks(1);
        wr(A_CTRL, 16'h0000);
        expect_rd(A_DAY, 16'h0000, "R10 day wraps to zero");

        // R8: write on a tick cycle drops the advance
        set_time(16'd0, 16'h0000, 16'd10);
        wr(A_CTRL, EN);
        wait_one_tick();
        bus_addr = A_HM; bus_wdata = 16'h0205; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        wr(A_CTRL, 16'h0000);
        expect_rd(A_SEC, 16'd10, "R8 advance dropped");
        expect_rd(A_HM, 16'h0205, "R8 hm loaded");

        // R9: alarm reached by counting
        wr(A_ADAY, 16'd0);
        wr(A_AHM, 16'h0000);
        wr(A_ASEC, 16'd3);
        set_time(16'd0, 16'h0000, 16'd0);
        a0 = alm_cnt;
        base = tick_cnt;
        wr(A_CTRL, EN);
        wait_ticks(5);
        wr(A_CTRL, 16'h0000);
        chk("R9 one pulse", alm_cnt - a0, 1);
        chk("R9 pulse after third tick", alm_at - base, 3);
        expect_rd(A_SEC, 16'd5, "R9 time kept running");

        // R9: equality created by write gives no pulse
        wr(A_ASEC, 16'd20);
        a0 = alm_cnt;
        wr(A_SEC, 16'd20);
        repeat (20) @(posedge clk);
        wr(A_CTRL, EN);
        wait_ticks(1);
        wr(A_CTRL, 16'h0000);
        @(negedge clk); #1;
        chk("R9 no pulse on written match", alm_cnt - a0, 0);
        expect_rd(A_SEC, 16'd21, "R9 counted past alarm");

        @(negedge clk); #1;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule